// File: doc/BRIEF.md
# Interprocessor Interrupt Command Unit

This block is the software-visible command side of one processor's local interrupt controller. Software programs a 64-bit interrupt command as two 32-bit words through a simple register port. The high word supplies the destination processor ID. The low word supplies the vector, delivery mode, addressing mode, trigger, level and recipient shorthand. Writing the low word is what sends the command. The block then presents one message on an outbound valid/ready port. A read-only status bit in the low word reads as pending until the port accepts that message.

Three small registers sit beside the command. The first holds the processor's local ID. The second holds the controller enable and the spurious vector. The third is an end-of-interrupt register. A write of any value to it produces a one-cycle pulse, and it always reads zero.

Software sends one message like this: it sets the high word, writes the low word, then polls the status bit until it drops. Writes to the low word are dropped in two cases: while a message is still outstanding, and while the controller is disabled.

Top module: `ipi_cmd_unit`

## Requirements
- R1: After reset:
  - every readable register reads zero, except the spurious/enable register at 0x0F0, which reads 0x000000FF (disabled, vector 0xFF);
  - msg_valid is 0;
  - eoi_pulse is 0.
- R2: The local ID register at 0x020 stores bits 31:24 of a write. Bits 23:0 always read zero.
- R3: The register at 0x0F0 keeps the enable in bit 8 and the spurious vector in bits 7:0. Bits 31:9 read zero.
- R4: The high command word at 0x310 keeps the destination in bits 31:24. Bits 23:0 read zero.
- R5: The low command word at 0x300 reads back the following fields. The message port carries each field unchanged.

  | Bits | Field | Encoding |
  |---|---|---|
  | 7:0 | vector | |
  | 10:8 | delivery mode | 000 fixed, 001 lowest priority, 010 system management, 100 non-maskable, 101 init, 110 start-up |
  | 11 | destination mode | 1 logical, 0 physical |
  | 12 | delivery status | read-only |
  | 14 | level | 1 assert |
  | 15 | trigger | 1 level, 0 edge |
  | 19:18 | shorthand | 00 use destination, 01 self, 10 all including self, 11 all excluding self |

  Bits 13, 17:16 and 31:20 read zero.
- R6: A write to 0x300 while enabled and idle launches a message.
  - From the next cycle, msg_valid is 1 and bit 12 of 0x300 reads 1.
  - The message fields equal the written fields.
  - msg_dest equals the high-word destination at the time of the write.
- R7: In the cycle after a cycle with msg_valid and msg_ready both high, msg_valid is 0 and bit 12 reads 0.
- R8: While msg_valid is high and msg_ready is low, all message fields stay stable. A later write to 0x310 does not change msg_dest.
- R9: A write to 0x300 while a message is pending is dropped. This includes a write in the very cycle the message is accepted. The stored fields, the port fields and the status stay as they were.
- R10: While the enable bit is 0, a write to 0x300 launches nothing and leaves the stored low-word fields unchanged.
- R11: Software cannot set or clear bit 12. A value written there has no effect on the status.
- R12: Every write to 0x0B0, whatever its data, makes eoi_pulse high for exactly the following cycle. A read of 0x0B0 returns zero.
- R13: Reads of any other address return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| msg_valid | output | 1 | Outbound message valid |
| msg_ready | input | 1 | Outbound message accepted |
| msg_vector | output | 8 | Message vector |
| msg_mode | output | 3 | Message delivery mode |
| msg_logical | output | 1 | Logical destination mode |
| msg_level | output | 1 | Level (assert/de-assert) |
| msg_trigger | output | 1 | Trigger (1 level, 0 edge) |
| msg_short | output | 2 | Recipient shorthand |
| msg_dest | output | 8 | Destination ID |
| eoi_pulse | output | 1 | One-cycle end-of-interrupt pulse |

## Verification
Acceptance of an outstanding message and a new low-word write can land on the same clock edge. The bench provokes this by raising msg_ready and writing a different low word in the same cycle. The result must show the message gone and the status idle, with the stored and port fields still holding the old command, so the write is judged dropped. A write during a long stall and a write while disabled are checked the same way, through readback and the port.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int ID_W   = 8;
    localparam int VEC_W  = 8;

    localparam logic [ADDR_W-1:0] OFF_ID   = 12'h020;
    localparam logic [ADDR_W-1:0] OFF_EOI  = 12'h0B0;
    localparam logic [ADDR_W-1:0] OFF_SPUR = 12'h0F0;
    localparam logic [ADDR_W-1:0] OFF_LO   = 12'h300;
    localparam logic [ADDR_W-1:0] OFF_HI   = 12'h310;

    // Command fields as software writes them in the low word
    typedef struct packed {
        logic [VEC_W-1:0] vector;
        logic [2:0]       mode;
        logic             logical;
        logic             level;
        logic             trigger;
        logic [1:0]       short;
    } ipi_cmd_t;

    typedef struct packed {
        ipi_cmd_t        cmd;
        logic [ID_W-1:0] dest;
    } ipi_msg_t;

    function automatic ipi_cmd_t unpack_lo(input logic [DATA_W-1:0] w);
        ipi_cmd_t c;
        c.vector  = w[7:0];
        c.mode    = w[10:8];
        c.logical = w[11];
        c.level   = w[14];
        c.trigger = w[15];
        c.short   = w[19:18];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] pack_lo(input ipi_cmd_t c, input logic busy);
        return {12'd0, c.short, 2'd0, c.trigger, c.level, 1'b0, busy,
                c.logical, c.mode, c.vector};
    endfunction
endpackage

// File: rtl/ipi_cfg_regs.sv
module ipi_cfg_regs
    import ipi_pkg::*;
#(
    parameter logic [VEC_W-1:0] SPUR_RST = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_id,
    input  logic              wr_spur,
    input  logic              wr_hi,
    input  logic              wr_eoi,
    input  logic [DATA_W-1:0] wdata,
    output logic [ID_W-1:0]   local_id,
    output logic              enable,
    output logic [VEC_W-1:0]  spur_vec,
    output logic [ID_W-1:0]   dest,
    output logic              eoi_pulse
);
    typedef struct packed {
        logic [ID_W-1:0]  id;
        logic             en;
        logic [VEC_W-1:0] spur;
        logic [ID_W-1:0]  dest;
        logic             eoi;
    } cfg_t;

    cfg_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.eoi = wr_eoi;
        if (wr_id)   st_d.id   = wdata[DATA_W-1 -: ID_W];
        if (wr_hi)   st_d.dest = wdata[DATA_W-1 -: ID_W];
        if (wr_spur) begin
            st_d.en   = wdata[VEC_W];
            st_d.spur = wdata[VEC_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.spur <= SPUR_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign local_id  = st_q.id;
    assign enable    = st_q.en;
    assign spur_vec  = st_q.spur;
    assign dest      = st_q.dest;
    assign eoi_pulse = st_q.eoi;
endmodule

// File: rtl/ipi_launch.sv
module ipi_launch
    import ipi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic [DATA_W-1:0] wdata,
    input  logic              enable,
    input  logic [ID_W-1:0]   dest_in,
    input  logic              msg_ready,
    output ipi_cmd_t          cmd,
    output ipi_msg_t          msg,
    output logic              busy
);
    typedef struct packed {
        ipi_cmd_t        cmd;
        logic [ID_W-1:0] dest;
        logic            busy;
    } launch_t;

    launch_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // acceptance and a new write seen in one cycle: the write is dropped
        if (st_q.busy) begin
            if (msg_ready) st_d.busy = 1'b0;
        end else if (wr_lo && enable) begin
            st_d.cmd  = unpack_lo(wdata);
            st_d.dest = dest_in;
            st_d.busy = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmd      = st_q.cmd;
    assign msg.cmd  = st_q.cmd;
    assign msg.dest = st_q.dest;
    assign busy     = st_q.busy;
endmodule

// File: rtl/ipi_cmd_unit.sv
module ipi_cmd_unit
    import ipi_pkg::*;
#(
    parameter logic [VEC_W-1:0] SPUR_RST = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [VEC_W-1:0]  msg_vector,
    output logic [2:0]        msg_mode,
    output logic              msg_logical,
    output logic              msg_level,
    output logic              msg_trigger,
    output logic [1:0]        msg_short,
    output logic [ID_W-1:0]   msg_dest,
    output logic              eoi_pulse
);
    localparam int PAD_ID = DATA_W - ID_W;
    localparam int PAD_SP = DATA_W - VEC_W - 1;

    logic            cfg_en;
    logic [ID_W-1:0] cfg_id, cfg_dest;
    logic [VEC_W-1:0] cfg_spur;
    ipi_cmd_t        lo_cmd;
    ipi_msg_t        out_msg;
    logic            lo_busy;

    logic wr_id, wr_spur, wr_hi, wr_eoi, wr_lo;
    assign wr_id   = reg_wr && (reg_addr == OFF_ID);
    assign wr_spur = reg_wr && (reg_addr == OFF_SPUR);
    assign wr_hi   = reg_wr && (reg_addr == OFF_HI);
    assign wr_eoi  = reg_wr && (reg_addr == OFF_EOI);
    assign wr_lo   = reg_wr && (reg_addr == OFF_LO);

    ipi_cfg_regs #(.SPUR_RST(SPUR_RST)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .wr_id(wr_id), .wr_spur(wr_spur), .wr_hi(wr_hi), .wr_eoi(wr_eoi),
        .wdata(reg_wdata),
        .local_id(cfg_id), .enable(cfg_en), .spur_vec(cfg_spur),
        .dest(cfg_dest), .eoi_pulse(eoi_pulse)
    );

    ipi_launch u_launch (
        .clk(clk), .rst_n(rst_n),
        .wr_lo(wr_lo), .wdata(reg_wdata), .enable(cfg_en),
        .dest_in(cfg_dest), .msg_ready(msg_ready),
        .cmd(lo_cmd), .msg(out_msg), .busy(lo_busy)
    );

    always_comb begin
        unique case (reg_addr)
            OFF_ID:   reg_rdata = {cfg_id, {PAD_ID{1'b0}}};
            OFF_SPUR: reg_rdata = {{PAD_SP{1'b0}}, cfg_en, cfg_spur};
            OFF_HI:   reg_rdata = {cfg_dest, {PAD_ID{1'b0}}};
            OFF_LO:   reg_rdata = pack_lo(lo_cmd, lo_busy);
            default:  reg_rdata = '0;
        endcase
    end

    assign msg_valid   = lo_busy;
    assign msg_vector  = out_msg.cmd.vector;
    assign msg_mode    = out_msg.cmd.mode;
    assign msg_logical = out_msg.cmd.logical;
    assign msg_level   = out_msg.cmd.level;
    assign msg_trigger = out_msg.cmd.trigger;
    assign msg_short   = out_msg.cmd.short;
    assign msg_dest    = out_msg.dest;
endmodule

// File: rtl/ipi_cmd_unit_chk.sv
module ipi_cmd_unit_chk
    import ipi_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              msg_valid,
    input logic              msg_ready,
    input logic [VEC_W-1:0]  msg_vector,
    input logic [2:0]        msg_mode,
    input logic [1:0]        msg_short,
    input logic [ID_W-1:0]   msg_dest,
    input logic              eoi_pulse,
    input logic              enable
);
    assert_launch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFF_LO && enable && !msg_valid) |=> msg_valid);

    assert_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_ready) |=> !msg_valid);

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector) &&
        $stable(msg_mode) && $stable(msg_short) && $stable(msg_dest)));

    assert_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !msg_valid) |=> !msg_valid);

    assert_eoi_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFF_EOI) |=> eoi_pulse);

    assert_eoi_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == OFF_EOI) |=> !eoi_pulse);

    assert_eoi_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFF_EOI) |-> (reg_rdata == '0));
endmodule

bind ipi_cmd_unit ipi_cmd_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_rdata(reg_rdata), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_vector(msg_vector), .msg_mode(msg_mode), .msg_short(msg_short),
    .msg_dest(msg_dest), .eoi_pulse(eoi_pulse), .enable(cfg_en)
);

// File: tb/ipi_cmd_unit_bench.sv
module ipi_cmd_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        msg_valid, msg_ready = 1'b0;
    logic [7:0]  msg_vector, msg_dest;
    logic [2:0]  msg_mode;
    logic        msg_logical, msg_level, msg_trigger, eoi_pulse;
    logic [1:0]  msg_short;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    ipi_cmd_unit u_ipi_cmd_unit (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic accept;
        @(negedge clk);
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
    endtask

    function automatic logic [31:0] lo_word(input logic [7:0] v, input logic [2:0] m,
            input logic lg, input logic lv, input logic tr, input logic [1:0] s, input logic b12);
        return (32'(s) << 18) | (32'(tr) << 15) | (32'(lv) << 14) | (32'(b12) << 12) |
               (32'(lg) << 11) | (32'(m) << 8) | 32'(v);
    endfunction

    function automatic logic [31:0] port_word;
        return lo_word(msg_vector, msg_mode, msg_logical, msg_level, msg_trigger, msg_short, 1'b0);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d, w, old;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        rd(12'h020, d); chk(d == 0, "R1 id", d, 0);
        rd(12'h0F0, d); chk(d == 32'hFF, "R1 spur", d, 32'hFF);
        rd(12'h310, d); chk(d == 0, "R1 hi", d, 0);
        rd(12'h300, d); chk(d == 0, "R1 lo", d, 0);
        chk(!msg_valid && !eoi_pulse, "R1 outputs", {msg_valid, eoi_pulse}, 0);

        // R10/R11 disabled: no launch, bit 12 not settable
        wr(12'h300, lo_word(8'h33, 3'd5, 1, 1, 1, 2'd3, 1'b1));
        chk(!msg_valid, "R10 no launch", msg_valid, 0);
        rd(12'h300, d); chk(d == 0, "R10 R11 lo unchanged", d, 0);

        // R2 id sweep
        for (int i = 0; i < 256; i++) begin
            wr(12'h020, {i[7:0], 24'hABCDEF});
            rd(12'h020, d); chk(d == {i[7:0], 24'h0}, "R2 id", d, {i[7:0], 24'h0});
        end

        // R3 spurious register
        wr(12'h0F0, 32'hFFFF_FE5A);
        rd(12'h0F0, d); chk(d == 32'h05A, "R3 disable", d, 32'h05A);
        wr(12'h0F0, 32'hFFFF_FF3C);
        rd(12'h0F0, d); chk(d == 32'h13C, "R3 enable", d, 32'h13C);

        // R13 unmapped
        rd(12'h304, d); chk(d == 0, "R13 unmapped", d, 0);
        rd(12'h000, d); chk(d == 0, "R13 unmapped", d, 0);

        // R4..R7 sweep of modes, shorthands, trigger/level, dest mode
        for (int m = 0; m < 8; m++)
            for (int s = 0; s < 4; s++)
                for (int t = 0; t < 8; t++) begin
                    logic [7:0] v, ds;
                    v  = 8'((m * 32 + s * 8 + t) ^ 8'hA5);
                    ds = v + 8'd17;
                    wr(12'h310, {ds, 24'hFFFFFF});
                    rd(12'h310, d); chk(d == {ds, 24'h0}, "R4 hi", d, {ds, 24'h0});
                    w = lo_word(v, 3'(m), t[0], t[1], t[2], 2'(s), 1'b0) | 32'hFFF2_2000;
                    wr(12'h300, w);
                    chk(msg_valid, "R6 valid", msg_valid, 1);
                    old = lo_word(v, 3'(m), t[0], t[1], t[2], 2'(s), 1'b0);
                    chk(port_word() == old && msg_dest == ds, "R5 R6 port fields",
                        {port_word()[23:0], msg_dest}, {old[23:0], ds});
                    rd(12'h300, d);
                    chk(d == (old | 32'h1000), "R5 R6 readback", d, old | 32'h1000);
                    accept();
                    chk(!msg_valid, "R7 cleared", msg_valid, 0);
                    rd(12'h300, d); chk(d == old, "R7 status idle", d, old);
                end

        // R8/R9 stall: write hi and lo while pending
        old = lo_word(8'h42, 3'd6, 0, 1, 0, 2'd3, 1'b0);
        wr(12'h310, 32'h7700_0000);
        wr(12'h300, old);
        repeat (3) @(negedge clk);
        wr(12'h310, 32'h1100_0000);
        wr(12'h300, lo_word(8'h99, 3'd1, 1, 0, 1, 2'd1, 1'b0));
        chk(msg_valid && port_word() == old && msg_dest == 8'h77, "R8 R9 held",
            {port_word()[23:0], msg_dest}, {old[23:0], 8'h77});
        rd(12'h300, d); chk(d == (old | 32'h1000), "R9 lo unchanged", d, old | 32'h1000);

        // R9 write in the same cycle as acceptance
        @(negedge clk);
        msg_ready = 1'b1; reg_wr = 1'b1; reg_addr = 12'h300;
        reg_wdata = lo_word(8'hEE, 3'd0, 0, 0, 0, 2'd0, 1'b0);
        @(negedge clk);
        msg_ready = 1'b0; reg_wr = 1'b0;
        chk(!msg_valid, "R9 same-cycle no relaunch", msg_valid, 0);
        rd(12'h300, d); chk(d == old, "R9 same-cycle dropped", d, old);

        // R12 EOI pulses, back to back, and read zero
        wr(12'h0B0, 32'h0);
        chk(eoi_pulse, "R12 pulse", eoi_pulse, 1);
        @(negedge clk);
        chk(!eoi_pulse, "R12 single", eoi_pulse, 0);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 12'h0B0; reg_wdata = 32'hDEADBEEF;
        @(negedge clk);
        chk(eoi_pulse, "R12 first of two", eoi_pulse, 1);
        @(negedge clk);
        reg_wr = 1'b0;
        chk(eoi_pulse, "R12 second of two", eoi_pulse, 1);
        @(negedge clk);
        chk(!eoi_pulse, "R12 ends", eoi_pulse, 0);
        rd(12'h0B0, d); chk(d == 0, "R12 reads zero", d, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule